// File: doc/BRIEF.md
# Stack and Interrupt Control Sequencer

This block is the part of an 8-bit processor core that handles every operation touching the hardware stack or the fixed vectors at the top of memory. These are: a power-on style restart, a software break (an undefined opcode is handled the same way), subroutine call and return, return from interrupt, and pushing and pulling the status byte. The sequencer owns the 8-bit stack pointer. The stack sits in page 1 of a 16-bit byte-wide address space.

The core gives it a 3-bit command code together with the current program counter, the current status byte and, for calls, the jump target. The sequencer then runs the push, pull and vector-read bus cycles, one access per clock. When the command completes it presents the new program counter, status byte and stack pointer, and raises a one-cycle done pulse. Read data on the memory port is expected in the same cycle as the read strobe. Address generation and arithmetic stay with the rest of the core.

Top module: `stk_irq_seq`

## Requirements
- R1: After rst_n is released, the sequencer is idle with sp_out = 0xFF, pc_out = 0x0000, sr_out = 0x24, and done, mem_wr and mem_rd low.
- R2: A push writes to address 0x0100 + SP and then decrements SP. A pull first increments SP and then reads 0x0100 + SP. SP wraps modulo 256 in both directions.
- R3: Each command makes at most one memory access per clock and never reads and writes at once. There is no access while idle. done is a one-cycle pulse in the cycle after the last access, and busy is low in that cycle. From acceptance, done arrives after this many clocks: restart 8, break 6, call 3, return 3, interrupt return 4, status push 2, status pull 2.
- R4: Restart (code 0) waits five cycles and then reads 0xFFFC (new PC low byte) and 0xFFFD (high byte). It sets SP to 0xFF. The new status is the input status with bit 0x04 (interrupt disable) set and bit 0x08 (decimal) cleared.
- R5: Break (code 1) and undefined opcode (code 7) push PC+1 high byte, then low byte, then the status with bit 0x10 (break) set. They then read the new PC from 0xFFFE (low) and 0xFFFF (high). The output status is the input status with 0x04 set and no other change.
- R6: Call (code 2) pushes PC−1, high byte first and then low byte. The new PC is the call target, and the status is unchanged.
- R7: Return (code 3) pulls the low byte and then the high byte. The new PC is that value plus 1, modulo 65536.
- R8: Interrupt return (code 4) pulls the status byte first, then the PC low byte, then the high byte. It takes both unmodified.
- R9: Status push (code 5) writes the input status with 0x10 set. The output PC and status equal the inputs.
- R10: Status pull (code 6) reads one byte. The new status is that byte with bit 0x20 forced to 1.
- R11: cmd_valid and the command inputs are ignored while busy. The accesses and results of the running command do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd | input | 3 | Command code (see R4 to R10) |
| pc_in | input | 16 | Current program counter |
| sr_in | input | 8 | Current status byte |
| call_target | input | 16 | Jump target for a call |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| sr_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Current stack pointer |

## Verification
The embedded properties check the bus discipline on every clock. Reads and writes are exclusive, and the bus is quiet when idle. Every stack write lands at page 1 plus the current SP and is followed by a decrement. Every stack read uses SP+1 and leaves SP there. Any other read targets the vector block, and done is a lone pulse after busy. The push order, the PC−1 and PC+1 adjustments, the forced break and bit-5 values, the vector byte order and the 256-byte wraparound all depend on the data. Only the bench's scenarios show them, by matching each bus access and each final result against an independently built expectation queue.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;

    localparam logic [DATA_W-1:0] SR_IRQ_DIS = 8'h04;
    localparam logic [DATA_W-1:0] SR_DECIMAL = 8'h08;
    localparam logic [DATA_W-1:0] SR_BRKFLAG = 8'h10;
    localparam logic [DATA_W-1:0] SR_ALWAYS1 = 8'h20;

    // vector block sits in the top four bytes of memory
    localparam logic [ADDR_W-3:0] VEC_BLOCK = '1;

    typedef enum logic [2:0] {
        CMD_RESET   = 3'd0,
        CMD_BREAK   = 3'd1,
        CMD_CALL    = 3'd2,
        CMD_RETURN  = 3'd3,
        CMD_IRET    = 3'd4,
        CMD_PUSH_SR = 3'd5,
        CMD_PULL_SR = 3'd6,
        CMD_UNDEF   = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {UOP_WAIT, UOP_PUSH, UOP_PULL, UOP_VEC} uop_e;
    typedef enum logic [1:0] {WSRC_RHI, WSRC_RLO, WSRC_SR} wsrc_e;
    typedef enum logic [1:0] {DST_NONE, DST_LO, DST_HI, DST_SR} dst_e;

    typedef struct packed {
        uop_e       op;
        wsrc_e      wsrc;
        dst_e       dst;
        logic [1:0] vsel;
        logic       last;
    } uop_t;

endpackage

// File: rtl/stk_uop_decode.sv
module stk_uop_decode
    import stk_pkg::*;
#(
    parameter int RST_WAIT = 5,
    parameter int STEP_W   = 3
) (
    input  cmd_e              cmd,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);

    always_comb begin
        uop.op   = UOP_WAIT;
        uop.wsrc = WSRC_SR;
        uop.dst  = DST_NONE;
        uop.vsel = 2'd0;
        uop.last = 1'b0;
        unique case (cmd)
            CMD_RESET: begin
                if (int'(step) < RST_WAIT) begin
                    uop.op = UOP_WAIT;
                end else if (int'(step) == RST_WAIT) begin
                    uop.op   = UOP_VEC;
                    uop.dst  = DST_LO;
                    uop.vsel = 2'd0;
                end else begin
                    uop.op   = UOP_VEC;
                    uop.dst  = DST_HI;
                    uop.vsel = 2'd1;
                    uop.last = 1'b1;
                end
            end
            CMD_BREAK, CMD_UNDEF: begin
                case (step)
                    STEP_W'(0): begin uop.op = UOP_PUSH; uop.wsrc = WSRC_RHI; end
                    STEP_W'(1): begin uop.op = UOP_PUSH; uop.wsrc = WSRC_RLO; end
                    STEP_W'(2): begin uop.op = UOP_PUSH; uop.wsrc = WSRC_SR;  end
                    STEP_W'(3): begin uop.op = UOP_VEC;  uop.dst = DST_LO; uop.vsel = 2'd2; end
                    default: begin
                        uop.op = UOP_VEC; uop.dst = DST_HI; uop.vsel = 2'd3; uop.last = 1'b1;
                    end
                endcase
            end
            CMD_CALL: begin
                uop.op = UOP_PUSH;
                if (step == '0) uop.wsrc = WSRC_RHI;
                else begin uop.wsrc = WSRC_RLO; uop.last = 1'b1; end
            end
            CMD_RETURN: begin
                uop.op = UOP_PULL;
                if (step == '0) uop.dst = DST_LO;
                else begin uop.dst = DST_HI; uop.last = 1'b1; end
            end
            CMD_IRET: begin
                uop.op = UOP_PULL;
                case (step)
                    STEP_W'(0): uop.dst = DST_SR;
                    STEP_W'(1): uop.dst = DST_LO;
                    default: begin uop.dst = DST_HI; uop.last = 1'b1; end
                endcase
            end
            CMD_PUSH_SR: begin
                uop.op   = UOP_PUSH;
                uop.wsrc = WSRC_SR;
                uop.last = 1'b1;
            end
            CMD_PULL_SR: begin
                uop.op   = UOP_PULL;
                uop.dst  = DST_SR;
                uop.last = 1'b1;
            end
            default: uop.last = 1'b1;
        endcase
    end

endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pull,
    input  logic              load_top,
    output logic [7:0]        sp,
    output logic [ADDR_W-1:0] addr
);

    logic [7:0] sp_d, sp_q;
    logic [7:0] sp_inc;

    always_comb begin
        sp_inc = sp_q + 8'd1;
        sp_d   = sp_q;
        if (load_top)  sp_d = 8'hFF;
        else if (push) sp_d = sp_q - 8'd1;
        else if (pull) sp_d = sp_inc;
        addr = pull ? {STACK_PAGE, sp_inc} : {STACK_PAGE, sp_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= 8'hFF;
        else        sp_q <= sp_d;
    end

    assign sp = sp_q;

    // R2: a single stack step per cycle
    p_push_pull_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pull));
    // R4: the restart load never coincides with a stack step
    p_load_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_top |-> !(push || pull));

endmodule

// File: rtl/stk_irq_seq.sv
module stk_irq_seq
    import stk_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter int         RST_WAIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sr_in,
    input  logic [ADDR_W-1:0] call_target,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sr_out,
    output logic [7:0]        sp_out
);

    localparam int STEP_MIN = 3;
    localparam int STEP_W   = ($clog2(RST_WAIT + 2) > STEP_MIN) ? $clog2(RST_WAIT + 2) : STEP_MIN;

    typedef struct packed {
        logic              busy;
        cmd_e              cmd;
        logic [STEP_W-1:0] step;
        logic [ADDR_W-1:0] ret;
        logic [ADDR_W-1:0] hold;
        logic [DATA_W-1:0] wsr;
        logic [DATA_W-1:0] lo;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sr;
        logic              done;
    } st_t;

    localparam st_t ST_RESET = '{busy: 1'b0, cmd: CMD_RESET, step: '0, ret: '0, hold: '0,
                                 wsr: '0, lo: '0, pc: '0, sr: 8'h24, done: 1'b0};

    st_t               st_d, st_q;
    uop_t              uop;
    logic              push, pull, load_top;
    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] fetched;
    cmd_e              cmd_in;

    assign cmd_in = cmd_e'(cmd);

    stk_uop_decode #(.RST_WAIT(RST_WAIT), .STEP_W(STEP_W)) u_dec (
        .cmd  (st_q.cmd),
        .step (st_q.step),
        .uop  (uop)
    );

    stk_ptr_unit #(.STACK_PAGE(STACK_PAGE)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pull     (pull),
        .load_top (load_top),
        .sp       (sp_out),
        .addr     (ptr_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        push      = 1'b0;
        pull      = 1'b0;
        load_top  = 1'b0;
        mem_rd    = 1'b0;
        mem_wdata = '0;
        fetched   = {mem_rdata, st_q.lo};
        mem_addr  = (uop.op == UOP_VEC) ? {VEC_BLOCK, uop.vsel} : ptr_addr;

        if (!st_q.busy) begin
            if (cmd_valid) begin
                st_d.busy = 1'b1;
                st_d.cmd  = cmd_in;
                st_d.step = '0;
                st_d.wsr  = sr_in;
                st_d.lo   = '0;
                st_d.ret  = (cmd_in == CMD_CALL) ? pc_in - 16'd1 : pc_in + 16'd1;
                st_d.hold = (cmd_in == CMD_CALL) ? call_target : pc_in;
            end
        end else begin
            st_d.step = st_q.step + 1'b1;
            case (uop.op)
                UOP_PUSH: push = 1'b1;
                UOP_PULL: begin pull = 1'b1; mem_rd = 1'b1; end
                UOP_VEC:  mem_rd = 1'b1;
                default:  ;
            endcase
            case (uop.wsrc)
                WSRC_RHI: mem_wdata = st_q.ret[15:8];
                WSRC_RLO: mem_wdata = st_q.ret[7:0];
                default:  mem_wdata = st_q.wsr | SR_BRKFLAG;
            endcase
            if (mem_rd && uop.dst == DST_LO) st_d.lo  = mem_rdata;
            if (mem_rd && uop.dst == DST_SR) st_d.wsr = mem_rdata;

            if (uop.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                load_top  = (st_q.cmd == CMD_RESET);
                case (st_q.cmd)
                    CMD_RESET: begin
                        st_d.pc = fetched;
                        st_d.sr = (st_q.wsr | SR_IRQ_DIS) & ~SR_DECIMAL;
                    end
                    CMD_BREAK, CMD_UNDEF: begin
                        st_d.pc = fetched;
                        st_d.sr = st_q.wsr | SR_IRQ_DIS;
                    end
                    CMD_RETURN: begin
                        st_d.pc = fetched + 16'd1;
                        st_d.sr = st_q.wsr;
                    end
                    CMD_IRET: begin
                        st_d.pc = fetched;
                        st_d.sr = st_q.wsr;
                    end
                    CMD_PULL_SR: begin
                        st_d.pc = st_q.hold;
                        st_d.sr = mem_rdata | SR_ALWAYS1;
                    end
                    default: begin
                        st_d.pc = st_q.hold;
                        st_d.sr = st_q.wsr;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign mem_wr = push;
    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign pc_out = st_q.pc;
    assign sr_out = st_q.sr;

    p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_wr || mem_rd));
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[15:8] == STACK_PAGE && mem_addr[7:0] == sp_out));
    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_out == $past(sp_out) - 8'd1));
    p_pull_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr[15:8] == STACK_PAGE) |-> (mem_addr[7:0] == sp_out + 8'd1));
    p_pull_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr[15:8] == STACK_PAGE) |=> (sp_out == $past(mem_addr[7:0])));
    p_vec_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr[15:8] != STACK_PAGE) |-> (mem_addr[15:2] == VEC_BLOCK));
    p_cmd_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(st_q.cmd));

endmodule

// File: tb/stk_irq_seq_tb_top.sv
module stk_irq_seq_tb_top;
    import stk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd;
    logic [15:0] pc_in, call_target, mem_addr, pc_out;
    logic [7:0]  sr_in, mem_wdata, mem_rdata, sr_out, sp_out;
    logic        mem_wr, mem_rd, busy, done;

    always #5 clk = ~clk;

    stk_irq_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .pc_in(pc_in), .sr_in(sr_in), .call_target(call_target),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pc_out(pc_out), .sr_out(sr_out), .sp_out(sp_out)
    );

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 completion
        logic [15:0] a;
        logic [7:0]  d;
        logic [15:0] pc;
        logic [7:0]  sr;
        logic [7:0]  sp;
        int          lat;
        string       req;
    } exp_t;

    exp_t        sb[$];
    exp_t        mon_e;
    int          n_chk = 0, n_bad = 0, cyc = 0, t_issue = 0;
    logic [7:0]  stk_mem [0:255];
    logic [7:0]  ref_stk [0:255];
    logic [7:0]  vec     [0:3];
    logic [7:0]  m_sp;

    always @(posedge clk) cyc <= cyc + 1;

    // environment memory: page 1 plus the vector block
    always_comb begin
        if (mem_addr[15:8] == 8'h01)         mem_rdata = stk_mem[mem_addr[7:0]];
        else if (mem_addr[15:2] == 14'h3FFF) mem_rdata = vec[mem_addr[1:0]];
        else                                 mem_rdata = 8'hEE;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) stk_mem[i] <= 8'(i) ^ 8'hA5;
        end else if (mem_wr && mem_addr[15:8] == 8'h01) begin
            stk_mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: every bus access and every completion pops one expected item
    always @(negedge clk) begin
        if (rst_n && (mem_wr || mem_rd || done)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3", "unexpected activity", int'({mem_wr, mem_rd, done}), 0);
            end else begin
                mon_e = sb.pop_front();
                if (mon_e.kind == 2) begin
                    chk(done, mon_e.req, "completion kind", int'(done), 1);
                    chk(pc_out == mon_e.pc, mon_e.req, "pc_out", int'(pc_out), int'(mon_e.pc));
                    chk(sr_out == mon_e.sr, mon_e.req, "sr_out", int'(sr_out), int'(mon_e.sr));
                    chk(sp_out == mon_e.sp, mon_e.req, "sp_out", int'(sp_out), int'(mon_e.sp));
                    chk(cyc - t_issue == mon_e.lat, "R3", "done latency", cyc - t_issue, mon_e.lat);
                end else begin
                    chk((mon_e.kind == 0) ? mem_wr : mem_rd, mon_e.req, "access kind",
                        int'({mem_wr, mem_rd}), mon_e.kind);
                    chk(mem_addr == mon_e.a, mon_e.req, "access address", int'(mem_addr), int'(mon_e.a));
                    if (mon_e.kind == 0)
                        chk(mem_wdata == mon_e.d, mon_e.req, "write data", int'(mem_wdata), int'(mon_e.d));
                end
            end
        end
    end

    task automatic ex_push(logic [7:0] d, string req);
        exp_t e;
        e.kind = 0; e.a = {8'h01, m_sp}; e.d = d; e.pc = '0; e.sr = '0; e.sp = '0; e.lat = 0; e.req = req;
        sb.push_back(e);
        ref_stk[m_sp] = d;
        m_sp = m_sp - 8'd1;
    endtask

    task automatic ex_pull(string req, output logic [7:0] d);
        exp_t e;
        m_sp = m_sp + 8'd1;
        e.kind = 1; e.a = {8'h01, m_sp}; e.d = '0; e.pc = '0; e.sr = '0; e.sp = '0; e.lat = 0; e.req = req;
        sb.push_back(e);
        d = ref_stk[m_sp];
    endtask

    task automatic ex_read(logic [15:0] a, string req);
        exp_t e;
        e.kind = 1; e.a = a; e.d = '0; e.pc = '0; e.sr = '0; e.sp = '0; e.lat = 0; e.req = req;
        sb.push_back(e);
    endtask

    task automatic ex_done(logic [15:0] pc, logic [7:0] sr, int lat, string req);
        exp_t e;
        e.kind = 2; e.a = '0; e.d = '0; e.pc = pc; e.sr = sr; e.sp = m_sp; e.lat = lat; e.req = req;
        sb.push_back(e);
    endtask

    // driver: builds the expectation, then applies the command
    task automatic issue(logic [2:0] c, logic [15:0] pc, logic [7:0] sr, logic [15:0] tgt,
                         string req, bit noise = 1'b0);
        logic [15:0] r;
        logic [7:0]  lo, hi, s;
        case (c)
            3'd0: begin
                ex_read(16'hFFFC, req); ex_read(16'hFFFD, req);
                m_sp = 8'hFF;
                ex_done({vec[1], vec[0]}, (sr | 8'h04) & ~8'h08, 8, req);
            end
            3'd1, 3'd7: begin
                r = pc + 16'd1;
                ex_push(r[15:8], req); ex_push(r[7:0], req); ex_push(sr | 8'h10, req);
                ex_read(16'hFFFE, req); ex_read(16'hFFFF, req);
                ex_done({vec[3], vec[2]}, sr | 8'h04, 6, req);
            end
            3'd2: begin
                r = pc - 16'd1;
                ex_push(r[15:8], req); ex_push(r[7:0], req);
                ex_done(tgt, sr, 3, req);
            end
            3'd3: begin
                ex_pull(req, lo); ex_pull(req, hi);
                ex_done({hi, lo} + 16'd1, sr, 3, req);
            end
            3'd4: begin
                ex_pull(req, s); ex_pull(req, lo); ex_pull(req, hi);
                ex_done({hi, lo}, s, 4, req);
            end
            3'd5: begin
                ex_push(sr | 8'h10, req);
                ex_done(pc, sr, 2, req);
            end
            default: begin
                ex_pull(req, s);
                ex_done(pc, s | 8'h20, 2, req);
            end
        endcase
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd = c; pc_in = pc; sr_in = sr; call_target = tgt; t_issue = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (noise) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd = 3'd0; pc_in = 16'hDEAD; sr_in = 8'hFF; call_target = 16'hBEEF;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R3", "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        vec[0] = 8'h00; vec[1] = 8'hC6; vec[2] = 8'h34; vec[3] = 8'hF2;
        for (int i = 0; i < 256; i++) ref_stk[i] = 8'(i) ^ 8'hA5;
        m_sp = 8'hFF;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd = '0; pc_in = '0; sr_in = '0; call_target = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset
        chk(sp_out == 8'hFF, "R1", "sp_out", int'(sp_out), 'hFF);
        chk(pc_out == 16'h0, "R1", "pc_out", int'(pc_out), 0);
        chk(sr_out == 8'h24, "R1", "sr_out", int'(sr_out), 'h24);
        chk(!done && !busy && !mem_wr && !mem_rd, "R1", "idle strobes",
            int'({done, busy, mem_wr, mem_rd}), 0);

        issue(3'd0, 16'h0000, 8'hCB, 16'h0, "R4");            // restart
        issue(3'd2, 16'h1234, 8'h81, 16'h4000, "R6");         // call
        issue(3'd2, 16'h1200, 8'h81, 16'h5000, "R6");         // call, PC-1 borrows
        issue(3'd3, 16'h5000, 8'h81, 16'h0, "R7");            // return
        issue(3'd3, 16'h4000, 8'h81, 16'h0, "R7");
        issue(3'd5, 16'h0777, 8'hC3, 16'h0, "R9");            // status push
        issue(3'd6, 16'h0888, 8'h00, 16'h0, "R10");           // status pull
        issue(3'd5, 16'h0777, 8'h00, 16'h0, "R9");
        issue(3'd6, 16'h0888, 8'hFF, 16'h0, "R10");
        issue(3'd1, 16'h20FF, 8'h41, 16'h0, "R5");            // break
        issue(3'd4, 16'h0000, 8'h00, 16'h0, "R8");            // interrupt return
        issue(3'd7, 16'hFFFF, 8'h08, 16'h0, "R5");            // undefined opcode, PC wraps
        issue(3'd4, 16'h0000, 8'h00, 16'h0, "R8");
        issue(3'd1, 16'h3000, 8'h00, 16'h0, "R11", 1'b1);     // request while busy
        issue(3'd4, 16'h0000, 8'h00, 16'h0, "R11");
        // R2: wraparound of the stack pointer in both directions
        issue(3'd3, 16'h0000, 8'h00, 16'h0, "R2");            // pull wraps FF->00->01
        issue(3'd5, 16'h0000, 8'h02, 16'h0, "R2");
        issue(3'd5, 16'h0000, 8'h80, 16'h0, "R2");            // push wraps 00->FF
        issue(3'd6, 16'h0000, 8'h00, 16'h0, "R2");
        issue(3'd6, 16'h0000, 8'h00, 16'h0, "R2");
        issue(3'd0, 16'h0000, 8'h08, 16'h0, "R4");            // restart resets SP
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R3", "pending expectations", sb.size(), 0);
        summary();
        $finish;
    end

endmodule